// File: doc/BRIEF.md
# SDRAM Write-Burst Interrupt Sequencer

This block sits on the controller side of a single synchronous DRAM with four banks and a 32-bit data bus. It takes one request at a time, opens the addressed row, starts a write burst of length 4 and then cuts the burst short after a chosen number of wanted beats. The cut is made either by a read of the same column or by a precharge of the bank (or of all banks).

The block places the read in the cycle right after the last wanted beat. It stops driving the data lines before the device starts returning data, and it captures the first returned word onto a registered output. For the precharge case it waits the write-recovery time, rounded up to whole clock cycles, and masks the byte lanes over the abandoned beats. After every precharge it holds off the next request until the row-precharge time has passed.

Device initialization, refresh and mode-register programming are handled elsewhere.

Top module: `wbi_seq`

## Requirements
- R1: While reset is asserted and in every idle cycle afterwards, the command is NOP, the data output enable is low, all mask bits are low, `rd_valid` is low and `req_ready` is high.
- R2: Commands are encoded as {CS#,RAS#,CAS#,WE#} with NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 and PRECHARGE=0010. An accepted request drives ACTIVE with its bank and row in the next cycle. WRITE follows RCD_CYC cycles after ACTIVE and carries the column on the low address bits with A10 low.
- R3: The write drives `req_nbeat`+1 beats (field value 0..3) with the output enable high. Beat i is `req_wdata[32*i +: 32]` and is driven in the i-th cycle, counting from the WRITE cycle as 0.
- R4: For `req_op`=0 a READ of the same bank and column, with A10 low, is issued in the cycle right after the last wanted beat.
- R5: The data output enable is low from the READ cycle onward, so no abandoned beat is ever driven.
- R6: The word on `sd_dq_in` at the clock edge that ends the cycle CL cycles after READ is presented on `rd_data` with `rd_valid` high for exactly the next cycle. In that same cycle a PRECHARGE of the bank with A10 low is issued.
- R7: For `req_op`=1 a PRECHARGE is issued ceil(TWR_NS/TCK_NS) cycles (at least 1) after the cycle of the last wanted beat, with A10 equal to `req_all`.
- R8: In the precharge case all mask bits are high from the cycle after the last wanted beat through the PRECHARGE cycle inclusive, and are low in every other cycle.
- R9: After any PRECHARGE, `req_ready` stays low for ceil(TRP_NS/TCK_NS)-1 further cycles before it rises. The next ACTIVE therefore comes no sooner than that many cycles after the precharge.
- R10: `req_ready` is low in every cycle from the accepted request's ACTIVE until the sequence ends, and a request is taken only on an edge where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 1 | 0: end burst with read, 1: end burst with precharge |
| req_all | input | 1 | Precharge all banks (precharge case only) |
| req_bank | input | 2 | Bank address |
| req_row | input | 12 | Row address |
| req_col | input | 9 | Column address |
| req_nbeat | input | 2 | Wanted write beats minus one |
| req_wdata | input | 128 | Four write beats, beat 0 in the low word |
| sd_cmd | output | 4 | {CS#,RAS#,CAS#,WE#} |
| sd_ba | output | 2 | Bank address to device |
| sd_addr | output | 12 | Address bus to device |
| sd_dq_out | output | 32 | Write data |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | 4 | Per-byte mask |
| sd_dq_in | input | 32 | Data from device |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |

## Verification
The bench builds the block with TCK_NS=10, TWR_NS=25, TRP_NS=18, CL=3 and RCD_CYC=2. Neither timing value divides evenly by the clock period, so the ceilings are exercised: recovery becomes 3 cycles and precharge-to-activate becomes 2. A three-cycle recovery gives a mask window that spans several NOP cycles before the precharge. CAS latency 3 leaves a gap of two released-bus cycles between the read and the captured word. Every wanted-beat count from 1 to 4 is run in both termination modes, including back-to-back requests that meet the row-precharge hold-off.

// File: rtl/wbi_pkg.sv
package wbi_pkg;

  // command codes {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_WR, ST_RDCMD, ST_CLW, ST_MSK, ST_PRE, ST_RPW
  } wbi_state_e;

  // time in ns to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned tck_ns);
    int unsigned c;
    c = (t_ns + tck_ns - 1) / tck_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wbi_timer.sv
module wbi_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  // a wait of D cycles is loaded with D on entry and ends when the count reads one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == W'(1));

  assert_timer_no_reload_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)) else $error("timer loaded with zero");
endmodule

// File: rtl/wbi_rdcap.sv
module wbi_rdcap #(
  parameter int DW = 32,
  parameter int CL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          cap_now
);
  logic [CL-1:0] sh;

  generate
    if (CL == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= rd_issue;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[CL-2:0], rd_issue};
      end
    end
  endgenerate

  assign cap_now = sh[CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_now;
      if (cap_now) rd_data <= dq_in;
    end
  end

  assert_capture_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |-> $past(rd_issue, CL)) else $error("capture not CL after read");
  assert_valid_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> rd_valid) else $error("capture without strobe");
endmodule

// File: rtl/wbi_seq.sv
module wbi_seq #(
  parameter int DW      = 32,
  parameter int BANKS   = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int AP_BIT  = 10,
  parameter int BURST   = 4,
  parameter int CL      = 2,
  parameter int RCD_CYC = 2,
  parameter int TCK_NS  = 7,
  parameter int TWR_NS  = 14,
  parameter int TRP_NS  = 20,
  localparam int BA_W   = $clog2(BANKS),
  localparam int BEAT_W = $clog2(BURST),
  localparam int NBYTE  = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic                req_all,
  input  logic [BA_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [BEAT_W-1:0]   req_nbeat,
  input  logic [BURST*DW-1:0] req_wdata,
  output logic [3:0]          sd_cmd,
  output logic [BA_W-1:0]     sd_ba,
  output logic [ROW_W-1:0]    sd_addr,
  output logic [DW-1:0]       sd_dq_out,
  output logic                sd_dq_oe,
  output logic [NBYTE-1:0]    sd_dqm,
  input  logic [DW-1:0]       sd_dq_in,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid
);
  import wbi_pkg::*;

  localparam int unsigned M_WR  = ns_to_cyc(TWR_NS, TCK_NS);
  localparam int unsigned N_RP  = ns_to_cyc(TRP_NS, TCK_NS);
  localparam int unsigned T_MAX = max2(max2(M_WR, N_RP), max2(RCD_CYC, CL));
  localparam int CNT_W = $clog2(T_MAX + 1);

  wbi_state_e st, st_nxt;
  logic [BEAT_W-1:0]   beat;
  logic                r_op, r_all;
  logic [BA_W-1:0]     r_bank;
  logic [ROW_W-1:0]    r_row;
  logic [COL_W-1:0]    r_col;
  logic [BEAT_W-1:0]   r_nb;
  logic [BURST*DW-1:0] r_wdata;
  logic                t_load, t_done;
  logic [CNT_W-1:0]    t_val;

  // named events
  logic accept, wr_last, act_issue, rd_issue, pre_issue, cap_now;
  assign accept    = (st == ST_IDLE) && req_valid;
  assign wr_last   = (st == ST_WR) && (beat == r_nb);
  assign act_issue = (sd_cmd == CMD_ACT);
  assign rd_issue  = (sd_cmd == CMD_RD);
  assign pre_issue = (sd_cmd == CMD_PRE);

  always_comb begin
    st_nxt = st;
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      ST_IDLE:  if (req_valid) st_nxt = ST_ACT;
      ST_ACT:   if (RCD_CYC > 1) begin
                  st_nxt = ST_RCD; t_load = 1'b1; t_val = CNT_W'(RCD_CYC - 1);
                end else st_nxt = ST_WR;
      ST_RCD:   if (t_done) st_nxt = ST_WR;
      ST_WR:    if (beat == r_nb) begin
                  if (!r_op) st_nxt = ST_RDCMD;
                  else if (M_WR > 1) begin
                    st_nxt = ST_MSK; t_load = 1'b1; t_val = CNT_W'(M_WR - 1);
                  end else st_nxt = ST_PRE;
                end
      ST_RDCMD: begin st_nxt = ST_CLW; t_load = 1'b1; t_val = CNT_W'(CL); end
      ST_CLW:   if (t_done) st_nxt = ST_PRE;
      ST_MSK:   if (t_done) st_nxt = ST_PRE;
      ST_PRE:   if (N_RP > 1) begin
                  st_nxt = ST_RPW; t_load = 1'b1; t_val = CNT_W'(N_RP - 1);
                end else st_nxt = ST_IDLE;
      ST_RPW:   if (t_done) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; beat <= '0;
      r_op <= 1'b0; r_all <= 1'b0; r_bank <= '0; r_row <= '0;
      r_col <= '0; r_nb <= '0; r_wdata <= '0;
    end else begin
      st   <= st_nxt;
      beat <= (st == ST_WR) ? beat + 1'b1 : '0;
      if (accept) begin
        r_op <= req_op; r_all <= req_all; r_bank <= req_bank; r_row <= req_row;
        r_col <= req_col; r_nb <= req_nbeat; r_wdata <= req_wdata;
      end
    end
  end

  wbi_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  // outputs decoded from state flops
  always_comb begin
    sd_cmd  = CMD_NOP;
    sd_addr = '0;
    case (st)
      ST_ACT:   begin sd_cmd = CMD_ACT; sd_addr = r_row; end
      ST_WR:    if (beat == '0) begin sd_cmd = CMD_WR; sd_addr = ROW_W'(r_col); end
      ST_RDCMD: begin sd_cmd = CMD_RD; sd_addr = ROW_W'(r_col); end
      ST_PRE:   begin sd_cmd = CMD_PRE; sd_addr[AP_BIT] = r_op & r_all; end
      default:  ;
    endcase
  end

  assign sd_ba     = r_bank;
  assign sd_dq_oe  = (st == ST_WR);
  assign sd_dq_out = sd_dq_oe ? r_wdata[beat*DW +: DW] : '0;
  assign sd_dqm    = {NBYTE{r_op && ((st == ST_MSK) || (st == ST_PRE))}};
  assign req_ready = (st == ST_IDLE);

  wbi_rdcap #(.DW(DW), .CL(CL)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dq_in(sd_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .cap_now(cap_now)
  );

  // spacing monitors for the assertions
  logic [CNT_W:0] since_last, since_pre;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_last <= '1;
      since_pre  <= '1;
    end else begin
      if (wr_last)                since_last <= (CNT_W+1)'(1);
      else if (since_last != '1)  since_last <= since_last + 1'b1;
      if (pre_issue)              since_pre <= (CNT_W+1)'(1);
      else if (since_pre != '1)   since_pre <= since_pre + 1'b1;
    end
  end

  assert_read_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_last && !r_op) |=> (sd_cmd == CMD_RD)) else $error("read not right after last beat");
  assert_bus_free_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !sd_dq_oe) else $error("DQ driven after read");
  assert_bus_free_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |-> (!sd_dq_oe && $past(!sd_dq_oe))) else $error("DQ contention");
  assert_pre_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_issue && r_op) |-> (since_last == (CNT_W+1)'(M_WR))) else $error("write recovery violated");
  assert_mask_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_last && r_op) |=> (sd_dqm == '1)) else $error("mask not raised");
  assert_mask_on_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_issue && r_op) |-> (sd_dqm == '1)) else $error("mask low at precharge");
  assert_act_after_rp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |-> (since_pre >= (CNT_W+1)'(N_RP))) else $error("precharge period violated");
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd != CMD_NOP) |-> !req_ready) else $error("ready during command");
endmodule

// File: tb/wbi_seq_test.sv
module wbi_seq_test;
  localparam int TCK = 10, TWR = 25, TRP = 18, CL = 3, RCD = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, req_all = 1'b0;
  logic [1:0] req_bank = '0, req_nbeat = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic [127:0] req_wdata = '0;
  logic req_ready, sd_dq_oe, rd_valid;
  logic [3:0] sd_cmd, sd_dqm;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [31:0] sd_dq_out, sd_dq_in, rd_data;

  always #5 clk = ~clk;

  wbi_seq #(.CL(CL), .RCD_CYC(RCD), .TCK_NS(TCK), .TWR_NS(TWR), .TRP_NS(TRP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_all(req_all), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_nbeat(req_nbeat), .req_wdata(req_wdata),
    .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .sd_dq_in(sd_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] dev_word(input logic [1:0] b, input logic [8:0] c);
    return 32'hC0DE0000 ^ {19'd0, b, 2'b00, c};
  endfunction

  // device stand-in: returns a word CL edges after a READ is registered
  logic [CL-1:0] dsh;
  logic [31:0] dpat;
  always @(posedge clk) begin
    if (!rst_n) begin
      dsh  <= '0;
      dpat <= '0;
    end else begin
      dsh <= {dsh[CL-2:0], sd_cmd == C_RD};
      if (sd_cmd == C_RD) dpat <= dev_word(sd_ba, sd_addr[8:0]);
    end
  end
  assign sd_dq_in = dsh[CL-1] ? dpat : 32'hBAD0BAD0;

  typedef struct {
    logic [3:0] cmd; logic [1:0] ba; logic [11:0] addr; logic oe; logic [31:0] dq;
    logic [3:0] dqm; logic rdy; logic rdv; logic [31:0] rdd; string tag;
  } exp_t;
  exp_t expq[$];
  int checks = 0, errors = 0;
  int m_wr = 0, n_rp = 0;

  function automatic exp_t mk(input logic [3:0] c, input logic [1:0] b,
                              input logic [11:0] a, input string t);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.oe = 1'b0; e.dq = '0; e.dqm = '0;
    e.rdy = 1'b0; e.rdv = 1'b0; e.rdd = '0; e.tag = t;
    return e;
  endfunction

  task automatic send(input logic op, input logic all, input logic [1:0] bank,
                      input logic [11:0] row, input logic [8:0] col,
                      input logic [1:0] nb, input logic [127:0] w);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_all = all; req_bank = bank;
    req_row = row; req_col = col; req_nbeat = nb; req_wdata = w;
    while (!req_ready) @(negedge clk);
    // R2: ACTIVE then WRITE RCD cycles later
    expq.push_back(mk(C_ACT, bank, row, "R2"));
    for (int i = 1; i < RCD; i++) expq.push_back(mk(C_NOP, bank, '0, "R2"));
    // R3: wanted beats
    for (int i = 0; i <= int'(nb); i++) begin
      e = mk((i == 0) ? C_WR : C_NOP, bank, {3'b000, col}, "R3");
      e.oe = 1'b1; e.dq = w[32*i +: 32];
      expq.push_back(e);
    end
    if (!op) begin
      expq.push_back(mk(C_RD, bank, {3'b000, col}, "R4"));        // R4
      for (int i = 0; i < CL; i++) expq.push_back(mk(C_NOP, bank, '0, "R5")); // R5
      e = mk(C_PRE, bank, '0, "R6");                               // R6
      e.rdv = 1'b1; e.rdd = dev_word(bank, col);
      expq.push_back(e);
    end else begin
      for (int i = 1; i < m_wr; i++) begin
        e = mk(C_NOP, bank, '0, "R8"); e.dqm = 4'hF; expq.push_back(e);   // R8
      end
      e = mk(C_PRE, bank, all ? 12'h400 : 12'h000, "R7");          // R7
      e.dqm = 4'hF;
      expq.push_back(e);
    end
    for (int i = 1; i < n_rp; i++) expq.push_back(mk(C_NOP, bank, '0, "R9")); // R9
    e = mk(C_NOP, bank, '0, "R9"); e.rdy = 1'b1; expq.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: one comparison per cycle, sampled after the edge has settled
  initial begin
    exp_t e;
    logic ok;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (expq.size() != 0) e = expq.pop_front();
        else begin
          e = mk(C_NOP, '0, '0, "R1"); e.rdy = 1'b1;   // R1 idle cycle
        end
        ok = (sd_cmd == e.cmd) && (req_ready == e.rdy) && (sd_dq_oe == e.oe) &&
             (sd_dqm == e.dqm) && (rd_valid == e.rdv) &&
             ((e.cmd == C_NOP) || ((sd_ba == e.ba) && (sd_addr == e.addr))) &&
             (!e.oe || (sd_dq_out == e.dq)) && (!e.rdv || (rd_data == e.rdd));
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s (R10 if ready differs): cmd=%b ba=%0d addr=%h oe=%b dq=%h dqm=%h rdy=%b rdv=%b rdd=%h exp cmd=%b ba=%0d addr=%h oe=%b dq=%h dqm=%h rdy=%b rdv=%b rdd=%h",
                   e.tag, sd_cmd, sd_ba, sd_addr, sd_dq_oe, sd_dq_out, sd_dqm, req_ready,
                   rd_valid, rd_data, e.cmd, e.ba, e.addr, e.oe, e.dq, e.dqm, e.rdy, e.rdv, e.rdd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (m_wr * TCK < TWR) m_wr++;
    while (n_rp * TCK < TRP) n_rp++;
    if (m_wr == 0) m_wr = 1;
    if (n_rp == 0) n_rp = 1;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    checks++;
    if (!(sd_cmd == C_NOP && !sd_dq_oe && sd_dqm == 4'h0 && !rd_valid && req_ready)) begin
      errors++;
      $display("FAIL R1 reset: cmd=%b oe=%b dqm=%h rdv=%b rdy=%b exp cmd=0111 oe=0 dqm=0 rdv=0 rdy=1",
               sd_cmd, sd_dq_oe, sd_dqm, rd_valid, req_ready);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b0, 1'b0, 2'd1, 12'h0A5, 9'h012, 2'd1, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    send(1'b0, 1'b0, 2'd2, 12'hFFF, 9'h1F0, 2'd0, {32'hDD, 32'hCC, 32'hBB, 32'hA0A0A0A0});
    send(1'b0, 1'b0, 2'd0, 12'h001, 9'h000, 2'd3, {32'h0F0F0F0F, 32'hF0F0F0F0, 32'h12345678, 32'h9ABCDEF0});
    repeat (3) @(negedge clk);
    send(1'b1, 1'b0, 2'd3, 12'h3C3, 9'h155, 2'd0, {32'h0, 32'h0, 32'h0, 32'h5A5A5A5A});
    send(1'b1, 1'b1, 2'd0, 12'h222, 9'h0AA, 2'd1, {32'h0, 32'h0, 32'hBEEF0001, 32'hBEEF0000});
    send(1'b1, 1'b0, 2'd2, 12'h777, 9'h1FF, 2'd2, {32'h0, 32'h03030303, 32'h02020202, 32'h01010101});
    send(1'b1, 1'b1, 2'd1, 12'h800, 9'h004, 2'd3, {32'hFACE0003, 32'hFACE0002, 32'hFACE0001, 32'hFACE0000});
    send(1'b0, 1'b0, 2'd3, 12'h456, 9'h0C8, 2'd2, {32'h0, 32'h77777777, 32'h66666666, 32'h55555555});
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule